// File: doc/BRIEF.md
# Dual-Phase PWM Timer

This block drives two complementary PWM pins from a single 16-bit down-counter. The counter alternates between a high-phase reload value and a low-phase reload value. A second down-counter, the arming counter, runs next to it. It counts down to zero and then waits there. When the phase counter next finishes a low phase, the block raises a one-cycle interrupt, the arming counter reloads, and a new high phase begins.

The timer advances only on clock-enable pulses. These come either from a slow tick input or from a fast tick input that passes through a power-of-two prescaler. The arming counter steps either on every timer tick or on every tenth one. An optional mode replaces the solid-high phase with a half-rate toggle. A freeze input holds every piece of state for as long as it is asserted.

Software programs the block through a simple write port. Address 0 is the control word, address 1 the high-phase reload, address 2 the low-phase reload and address 3 the arming reload. The whole block runs in one clock domain with a synchronous active-high reset.

Top module: `pwm_pair_timer`

## Requirements
- R1: While control bit 0 (run) is 0, including after reset, `pwm_a` is 0, `pwm_b` is 1 and `irq` is 0. Setting run restarts the timer from the start of a high phase with all three reload values freshly loaded.
- R2: Timer ticks are counted from enable as tick 0. Every period is M+N+2 ticks long. `pwm_a` is in its high phase for period positions 0..M and low for positions M+1..M+N+1. M, N and ON are written at addresses 1, 2 and 3.
- R3: `pwm_b` is always the inverse of `pwm_a` in the same cycle.
- R4: With control bit 3 at 1, `pwm_a` during the high phase is 1 at even period positions and 0 at odd ones. With bit 3 at 0, it is a constant 1.
- R5: `irq` pulses for one cycle on the tick that ends a low phase, but only if the arming counter was already zero before that tick. The arming counter then reloads from ON.
- R6: If the arming counter reaches zero on the same tick that ends a low phase, no interrupt fires on that tick. The interrupt fires at the next low-phase end.
- R7: With control bit 2 at 0 (the reset value), the arming counter steps on every 10th timer tick. With bit 2 at 1, it steps on every timer tick.
- R8: With control bit 1 at 0, timer ticks come from `tick_slow`. With bit 1 at 1, they come from the prescaled `tick_fast`. The unselected input has no effect.
- R9: Control bits 5:4 set the fast prescaler. Codes 0, 1, 2 and 3 give one timer tick per 1, 2, 4 and 8 fast ticks.
- R10: While `freeze` is 1, the counters, prescaler, divide-by-10 stage and outputs hold their values. Counting resumes from those values when `freeze` returns to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register address (0 control, 1 M, 2 N, 3 ON) |
| wr_data | input | 16 | Register write data |
| tick_slow | input | 1 | Slow-source clock enable |
| tick_fast | input | 1 | Fast-source clock enable, before the prescaler |
| freeze | input | 1 | Hold all counting while high |
| pwm_a | output | 1 | PWM output, high during the high phase |
| pwm_b | output | 1 | Complement of pwm_a |
| irq | output | 1 | One-cycle interrupt pulse |

## Verification
Two events can fall on the same timer tick: the arming counter's last decrement, and the phase counter's end of a low phase. The bench provokes this by setting ON to exactly M+N+2 with the divider bypassed. The countdown then lands on zero on the very tick that closes the first low phase. The check passes only if `irq` stays low on that tick and pulses one full period later. A run with ON one smaller checks that the interrupt fires on the first low-phase end.

// File: rtl/ppt_pkg.sv
package ppt_pkg;
  localparam int ADDR_W   = 2;
  localparam int A_CTRL   = 0;
  localparam int A_HIGH   = 1;
  localparam int A_LOW    = 2;
  localparam int A_ARM    = 3;
  localparam int CB_RUN   = 0;
  localparam int CB_FAST  = 1;
  localparam int CB_DVOFF = 2;
  localparam int CB_HALF  = 3;
  localparam int CB_PRE   = 4;

  typedef enum logic {PH_HIGH = 1'b0, PH_LOW = 1'b1} phase_e;
endpackage

// File: rtl/ppt_tick_gen.sv
module ppt_tick_gen #(
  parameter int PRE_W  = 2,
  parameter int ON_DIV = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic             freeze,
  input  logic             src_fast,
  input  logic [PRE_W-1:0] pre_code,
  input  logic             div_off,
  input  logic             tick_slow,
  input  logic             tick_fast,
  output logic             tmr_tick,
  output logic             arm_tick
);
  localparam int PC_W = (1 << PRE_W) - 1;
  localparam int DC_W = $clog2(ON_DIV);

  logic [PC_W-1:0] pc;
  logic [PC_W-1:0] mask;
  logic [DC_W-1:0] dc;
  logic            raw_slow, raw_fast;

  always_comb begin
    raw_slow = tick_slow & run & ~freeze;
    raw_fast = tick_fast & run & ~freeze;
    mask     = (PC_W'(1) << pre_code) - PC_W'(1);
    tmr_tick = src_fast ? (raw_fast && ((pc & mask) == mask)) : raw_slow;
    arm_tick = div_off ? tmr_tick : (tmr_tick && (dc == DC_W'(ON_DIV - 1)));
  end

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      pc <= '0;
      dc <= '0;
    end else begin
      if (src_fast && raw_fast) pc <= pc + PC_W'(1);
      if (tmr_tick) dc <= (dc == DC_W'(ON_DIV - 1)) ? '0 : dc + DC_W'(1);
    end
  end
endmodule

// File: rtl/ppt_phase_ctr.sv
module ppt_phase_ctr
  import ppt_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         run,
  input  logic         tick,
  input  logic         half_mode,
  input  logic [W-1:0] reload_high,
  input  logic [W-1:0] reload_low,
  output logic         low_end,
  output logic [W-1:0] cnt,
  output logic         pwm_a,
  output logic         pwm_b
);
  phase_e     ph, ph_n;
  logic [W-1:0] cnt_n;
  logic       half, half_n, pa_n;

  always_comb begin
    ph_n    = ph;
    cnt_n   = cnt;
    half_n  = half;
    low_end = run && tick && (cnt == '0) && (ph == PH_LOW);
    if (!run) begin
      ph_n   = PH_HIGH;
      cnt_n  = reload_high;
      half_n = 1'b1;
    end else if (tick) begin
      if (cnt == '0) begin
        ph_n   = (ph == PH_HIGH) ? PH_LOW : PH_HIGH;
        cnt_n  = (ph == PH_HIGH) ? reload_low : reload_high;
        half_n = 1'b1;
      end else begin
        cnt_n  = cnt - W'(1);
        half_n = ~half;
      end
    end
    pa_n = run && (ph_n == PH_HIGH) && (half_mode ? half_n : 1'b1);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ph    <= PH_HIGH;
      cnt   <= '0;
      half  <= 1'b1;
      pwm_a <= 1'b0;
      pwm_b <= 1'b1;
    end else begin
      ph    <= ph_n;
      cnt   <= cnt_n;
      half  <= half_n;
      pwm_a <= pa_n;
      pwm_b <= ~pa_n;
    end
  end
endmodule

// File: rtl/ppt_arm_ctr.sv
module ppt_arm_ctr #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         run,
  input  logic         tick,
  input  logic         fire,
  input  logic [W-1:0] reload,
  output logic         armed,
  output logic [W-1:0] cnt
);
  always_comb armed = (cnt == '0);

  always_ff @(posedge clk) begin
    if (rst)                    cnt <= '0;
    else if (!run || fire)      cnt <= reload;
    else if (tick && !armed)    cnt <= cnt - W'(1);
  end
endmodule

// File: rtl/pwm_pair_timer.sv
module pwm_pair_timer
  import ppt_pkg::*;
#(
  parameter int W      = 16,
  parameter int PRE_W  = 2,
  parameter int ON_DIV = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [W-1:0]      wr_data,
  input  logic              tick_slow,
  input  logic              tick_fast,
  input  logic              freeze,
  output logic              pwm_a,
  output logic              pwm_b,
  output logic              irq
);
  logic             run_bit, src_fast, div_off, half_mode;
  logic [PRE_W-1:0] pre_code;
  logic [W-1:0]     rl_high, rl_low, rl_arm;
  logic             tmr_tick, arm_tick, low_end, armed, fire;
  logic [W-1:0]     t0_cnt, arm_cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      run_bit   <= 1'b0;
      src_fast  <= 1'b0;
      div_off   <= 1'b0;
      half_mode <= 1'b0;
      pre_code  <= '0;
      rl_high   <= '0;
      rl_low    <= '0;
      rl_arm    <= '0;
    end else if (wr_en) begin
      case (wr_addr)
        ADDR_W'(A_CTRL): begin
          run_bit   <= wr_data[CB_RUN];
          src_fast  <= wr_data[CB_FAST];
          div_off   <= wr_data[CB_DVOFF];
          half_mode <= wr_data[CB_HALF];
          pre_code  <= wr_data[CB_PRE +: PRE_W];
        end
        ADDR_W'(A_HIGH): rl_high <= wr_data;
        ADDR_W'(A_LOW):  rl_low  <= wr_data;
        default:         rl_arm  <= wr_data;
      endcase
    end
  end

  ppt_tick_gen #(.PRE_W(PRE_W), .ON_DIV(ON_DIV)) u_tick (
    .clk(clk), .rst(rst), .run(run_bit), .freeze(freeze), .src_fast(src_fast),
    .pre_code(pre_code), .div_off(div_off), .tick_slow(tick_slow),
    .tick_fast(tick_fast), .tmr_tick(tmr_tick), .arm_tick(arm_tick)
  );

  ppt_phase_ctr #(.W(W)) u_phase (
    .clk(clk), .rst(rst), .run(run_bit), .tick(tmr_tick), .half_mode(half_mode),
    .reload_high(rl_high), .reload_low(rl_low), .low_end(low_end),
    .cnt(t0_cnt), .pwm_a(pwm_a), .pwm_b(pwm_b)
  );

  always_comb fire = low_end && armed;

  ppt_arm_ctr #(.W(W)) u_arm (
    .clk(clk), .rst(rst), .run(run_bit), .tick(arm_tick), .fire(fire),
    .reload(rl_arm), .armed(armed), .cnt(arm_cnt)
  );

  always_ff @(posedge clk) begin
    if (rst) irq <= 1'b0;
    else     irq <= fire;
  end
endmodule

// File: rtl/ppt_checker.sv
module ppt_checker #(
  parameter int W = 16
) (
  input logic         clk,
  input logic         rst,
  input logic         run,
  input logic         freeze,
  input logic         pwm_a,
  input logic         pwm_b,
  input logic         irq,
  input logic [W-1:0] t0_cnt,
  input logic [W-1:0] arm_cnt
);
  a_r3_complement: assert property (@(posedge clk) disable iff (rst)
    pwm_b == !pwm_a);

  a_r1_idle_quiet: assert property (@(posedge clk) disable iff (rst)
    !run |=> (!pwm_a && !irq));

  a_r5_single_pulse: assert property (@(posedge clk) disable iff (rst)
    irq |=> !irq);

  a_r5_irq_needs_armed: assert property (@(posedge clk) disable iff (rst)
    irq |-> ($past(arm_cnt) == '0));

  a_r5_irq_opens_high: assert property (@(posedge clk) disable iff (rst)
    irq |-> pwm_a);

  a_r10_freeze_hold: assert property (@(posedge clk) disable iff (rst)
    (run && freeze) |=> ($stable(t0_cnt) && $stable(arm_cnt) && !irq));
endmodule

bind pwm_pair_timer ppt_checker #(.W(W)) u_chk (
  .clk(clk), .rst(rst), .run(run_bit), .freeze(freeze), .pwm_a(pwm_a),
  .pwm_b(pwm_b), .irq(irq), .t0_cnt(t0_cnt), .arm_cnt(arm_cnt)
);

// File: tb/sim_pwm_pair_timer.sv
module sim_pwm_pair_timer;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 20000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic        tick_slow = 1'b0;
  logic        tick_fast = 1'b0;
  logic        freeze = 1'b0;
  logic        pwm_a, pwm_b, irq;

  int total = 0;
  int fails = 0;
  int cyc   = 0;
  bit done  = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  pwm_pair_timer u0 (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .tick_slow(tick_slow), .tick_fast(tick_fast), .freeze(freeze),
    .pwm_a(pwm_a), .pwm_b(pwm_b), .irq(irq)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == WATCHDOG && !done) begin
      total = total + 1;
      fails = fails + 1;
      $display("FAIL R1 watchdog: actual=hung expected=finished");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  task automatic chk(input string tag, input int j, input logic act, input logic exp);
    total = total + 1;
    if (act !== exp) begin
      fails = fails + 1;
      $display("FAIL %s cycle %0d: actual=%0b expected=%0b", tag, j, act, exp);
    end
  endtask

  function automatic int cw(bit run, bit fast, bit divoff, bit half, int pre);
    return int'(run) | (int'(fast) << 1) | (int'(divoff) << 2) | (int'(half) << 3) | (pre << 4);
  endfunction

  task automatic wr(input int a, input int d);
    @(negedge clk);
    tick_slow = 0; tick_fast = 0; freeze = 0;
    wr_en = 1; wr_addr = a[1:0]; wr_data = d[15:0];
    @(negedge clk);
    wr_en = 0;
  endtask

  // Reference from the requirements: timer tick count n, position r = n mod (M+N+2).
  task automatic run_seq(input string tag, input int cycles, input int mv, input int nv,
                         input int onv, input bit fast, input int pre, input bit div10,
                         input bit half, input int spacing, input int fza, input int fzb);
    int n = 0, pc = 0, d = 0, onl = onv, per = mv + nv + 2, r;
    bit frz, raw, tt, ot, fire, pa;
    wr(0, cw(0, fast, !div10, half, pre));
    wr(1, mv); wr(2, nv); wr(3, onv);
    wr(0, cw(1, fast, !div10, half, pre));
    for (int j = 1; j <= cycles; j++) begin
      frz = (j >= fza) && (j < fzb);
      raw = ((j % spacing) == 0) && !frz;
      freeze    = frz;
      tick_slow = fast ? 1'b1 : ((j % spacing) == 0);
      tick_fast = fast ? ((j % spacing) == 0) : 1'b1;
      tt = 0;
      if (fast) begin
        if (raw) begin
          pc++;
          tt = (pc % (1 << pre)) == 0;
        end
      end else tt = raw;
      ot = 0;
      if (tt) begin
        if (div10) begin
          d++;
          ot = (d % 10) == 0;
        end else ot = 1;
      end
      fire = 0;
      if (tt) begin
        n++;
        if ((n % per) == 0) fire = (onl == 0);
      end
      if (fire) onl = onv;
      else if (ot && onl > 0) onl--;
      r  = n % per;
      pa = (r <= mv) && (half ? ((r % 2) == 0) : 1'b1);
      @(negedge clk);
      chk({tag, " pwm_a"}, j, pwm_a, pa);
      chk("R3 pwm_b", j, pwm_b, !pa);
      chk({tag, " irq"}, j, irq, fire);
    end
  endtask

  task automatic t_reset();
    chk("R1 reset pwm_a", 0, pwm_a, 1'b0);
    chk("R1 reset pwm_b", 0, pwm_b, 1'b1);
    chk("R1 reset irq", 0, irq, 1'b0);
  endtask

  task automatic t_basic();      run_seq("R2", 30, 3, 2, 0, 0, 0, 0, 0, 1, 0, 0);  endtask
  task automatic t_half();       run_seq("R4", 30, 4, 1, 0, 0, 0, 0, 1, 1, 0, 0);  endtask
  task automatic t_arm_delay();  run_seq("R5", 40, 2, 2, 12, 0, 0, 0, 0, 1, 0, 0); endtask
  task automatic t_collide();
    run_seq("R6", 30, 3, 2, 7, 0, 0, 0, 0, 1, 0, 0);
    run_seq("R6 one-less", 20, 3, 2, 6, 0, 0, 0, 0, 1, 0, 0);
  endtask
  task automatic t_div10();      run_seq("R7", 45, 3, 2, 2, 0, 0, 1, 0, 1, 0, 0);  endtask
  task automatic t_slow_src();   run_seq("R8", 40, 1, 2, 1, 0, 0, 0, 0, 3, 0, 0);  endtask
  task automatic t_prescale();
    run_seq("R9 div4", 50, 1, 1, 0, 1, 2, 0, 0, 1, 0, 0);
    run_seq("R9 div8", 70, 1, 1, 1, 1, 3, 0, 0, 1, 0, 0);
    run_seq("R9 div1", 30, 2, 1, 0, 1, 0, 0, 1, 2, 0, 0);
  endtask
  task automatic t_freeze();
    run_seq("R10", 50, 3, 2, 3, 0, 0, 0, 0, 1, 5, 13);
    run_seq("R10 fast", 80, 2, 1, 1, 1, 1, 1, 1, 1, 9, 20);
  endtask

  task automatic t_disable();
    run_seq("R1 pre", 9, 3, 2, 0, 0, 0, 0, 0, 1, 0, 0);
    wr(0, cw(0, 0, 1, 0, 0));
    for (int j = 1; j <= 6; j++) begin
      tick_slow = 1; tick_fast = 1;
      @(negedge clk);
      chk("R1 idle pwm_a", j, pwm_a, 1'b0);
      chk("R1 idle pwm_b", j, pwm_b, 1'b1);
      chk("R1 idle irq", j, irq, 1'b0);
    end
    run_seq("R1 restart", 20, 3, 2, 0, 0, 0, 0, 0, 1, 0, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    t_reset();
    t_basic();
    t_half();
    t_arm_delay();
    t_collide();
    t_div10();
    t_slow_src();
    t_prescale();
    t_freeze();
    t_disable();
    done = 1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule